// File: doc/BRIEF.md
# Charging Port Mode Sequencer

This block decides which charging personality one downstream port presents to an attached device, and drives that port's power switch enable. When the upstream host is present, an enabled port offers the host-backed charging mode (CDP). When the upstream link is absent, the port either sits in the dedicated charging mode (DCP) or, with automatic operation on, rotates through several personalities. It starts with a resistor-divider signature (ACP1 or ACP2), then moves to an optional alternate signature, and then to DCP. If DCP is not recognised within a timeout, it returns to the divider signature. Every change of personality removes port power for a programmable gap so that the attached device sees a fresh attach.

Analog sensing is abstracted to two single-bit detect inputs: a pull-up seen on DP, and the data-voltage condition. All timing counts a one-cycle `tick` strobe, so that an integrator can set the time base and a bench can shorten it. The states are IDLE (charging disabled), HOST (CDP), DCP_FIX (DCP with automatic operation off), DIV (divider signature), ALT (alternate signature), DCP_AUTO (DCP inside the automatic cycle) and GAP (power removed, with a registered target state). The named transitions are:
- enable: IDLE goes to HOST, DCP_FIX or DIV.
- disable: any state goes to IDLE.
- divider exit: DIV goes to GAP targeting ALT or DCP_AUTO.
- alternate exit: ALT goes to GAP targeting DCP_AUTO.
- window expiry: DCP_AUTO goes to GAP targeting DIV.
- host arrival: any state goes to GAP targeting HOST.
- host loss: HOST goes to GAP targeting DCP_FIX or DIV.
- auto toggle: DCP_FIX and the automatic states switch between each other through GAP.
- gap end: GAP goes to its target.
- retarget: inside GAP the target changes and the gap timer restarts.

Top module: `chg_port_seq`

## Requirements
- R1: When `chg_en` is low, the cycle after it is sampled low shows mode NONE (`mode_oh` = 6'b000001) and port power inactive, with no gap, from any state including a gap.
- R2: With `chg_en` high and `up_vbus_ok` high, the port settles in CDP (`mode_oh` bit 1) with power active and stays there while both inputs hold.
- R3: With `chg_en` high, `up_vbus_ok` low and `auto_off` high, the port settles in DCP (`mode_oh` bit 2) with power active and stays there whatever the detect inputs do.
- R4: With automatic operation on (`auto_off` low) and upstream absent, the port enters the divider mode: ACP2 (`mode_oh` bit 4) when `hicur_en` is high, otherwise ACP1 (`mode_oh` bit 3). It remains there with power active while `dp_pullup` stays low.
- R5: A `dp_pullup` sampled high in the divider mode starts a gap, after which the port enters the alternate mode (`mode_oh` bit 5) if `alt_en` is high, and DCP otherwise.
- R6: A `dp_pullup` sampled high in the alternate mode starts a gap, after which the port enters DCP.
- R7: In DCP inside the automatic cycle, a `dp_pullup` or `dat_det` seen once holds the port in DCP. If neither is seen, the port leaves after `DCP_WAIT_TICKS` ticks (DCP_WAIT_TICKS+1 cycles with `tick` held high) through a gap back to the divider mode. No tick means no progress.
- R8: A gap removes port power for `gap_sel`×`GAP_UNIT_TICKS` ticks plus one cycle (gap_sel+0 gives a single cycle). During the gap `mode_oh` already shows the target mode.
- R9: `port_pwr` is active high when `pwr_pol` is 1 and active low when it is 0, including during reset.
- R10: `up_vbus_ok` rising in any automatic or fixed-DCP state takes a gap and then enters CDP. `up_vbus_ok` falling in CDP takes a gap and then enters the upstream-absent entry mode.
- R11: `mode_oh` always has exactly one bit set. The bit order is 0 NONE, 1 CDP, 2 DCP, 3 ACP1, 4 ACP2, 5 alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe for all timers |
| chg_en | input | 1 | Charging support enabled for this port |
| up_vbus_ok | input | 1 | Upstream VBUS above the valid threshold |
| auto_off | input | 1 | 1 disables automatic mode cycling |
| hicur_en | input | 1 | Selects ACP2 instead of ACP1 as divider mode |
| alt_en | input | 1 | Enables the alternate mode step |
| dp_pullup | input | 1 | Pull-up detected on DP |
| dat_det | input | 1 | Data-voltage condition detected |
| gap_sel | input | GAP_SEL_W | Gap length in units of GAP_UNIT_TICKS |
| pwr_pol | input | 1 | Power enable polarity, 1 = active high |
| mode_oh | output | 6 | One-hot charging mode indication |
| port_pwr | output | 1 | Port power switch enable pin |

## Verification
A wrong state shows at the ports in one of two ways: the one-hot mode takes a wrong value, or the power enable changes phase. A state that skips GAP shows no inactive power cycles on a mode change. A stuck DCP window shows power staying active past DCP_WAIT_TICKS+1 cycles. The bench therefore counts exact inactive and active cycle runs around each transition, and checks the mode in the first cycle after each change. A wrong disable or host decision appears one cycle after the input is sampled.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    localparam int MODE_W = 6;

    localparam int MI_NONE = 0;
    localparam int MI_CDP  = 1;
    localparam int MI_DCP  = 2;
    localparam int MI_ACP1 = 3;
    localparam int MI_ACP2 = 4;
    localparam int MI_ALT  = 5;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HOST     = 3'd1,
        ST_DCP_FIX  = 3'd2,
        ST_DIV      = 3'd3,
        ST_ALT      = 3'd4,
        ST_DCP_AUTO = 3'd5,
        ST_GAP      = 3'd6
    } chg_state_e;

    function automatic int mode_index(input chg_state_e st, input logic hicur);
        int idx;
        unique case (st)
            ST_HOST:                idx = MI_CDP;
            ST_DCP_FIX, ST_DCP_AUTO: idx = MI_DCP;
            ST_DIV:                 idx = hicur ? MI_ACP2 : MI_ACP1;
            ST_ALT:                 idx = MI_ALT;
            default:                idx = MI_NONE;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/chg_mode_fsm.sv
module chg_mode_fsm
    import chg_seq_pkg::*;
#(
    parameter int CNT_W          = 12,
    parameter int GAP_SEL_W      = 3,
    parameter int GAP_UNIT_TICKS = 200,
    parameter int DCP_WAIT_TICKS = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chg_en,
    input  logic                 up_vbus_ok,
    input  logic                 auto_off,
    input  logic                 alt_en,
    input  logic                 dp_pullup,
    input  logic                 dat_det,
    input  logic [GAP_SEL_W-1:0] gap_sel,
    input  logic [CNT_W-1:0]     gap_cnt,
    input  logic [CNT_W-1:0]     win_cnt,
    output chg_state_e           state,
    output chg_state_e           target,
    output logic                 gap_clr,
    output logic                 win_clr,
    output logic                 power_on
);
    localparam logic [CNT_W-1:0] UNIT_C = CNT_W'(GAP_UNIT_TICKS);
    localparam logic [CNT_W-1:0] WAIT_C = CNT_W'(DCP_WAIT_TICKS);

    chg_state_e       state_q, state_d;
    chg_state_e       tgt_q, tgt_d;
    logic             held_q, held_d;
    logic             retarget;
    logic [CNT_W-1:0] gap_len;
    chg_state_e       entry_st;
    logic             detect;
    logic             tgt_auto;

    assign gap_len  = CNT_W'(gap_sel) * UNIT_C;
    assign entry_st = auto_off ? ST_DCP_FIX : ST_DIV;
    assign detect   = dp_pullup | dat_det;
    assign tgt_auto = (tgt_q == ST_DIV) || (tgt_q == ST_ALT) || (tgt_q == ST_DCP_AUTO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= ST_IDLE;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            held_q  <= held_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        retarget = 1'b0;
        held_d   = (state_q == ST_DCP_AUTO) && (held_q || detect);
        if (!chg_en) begin
            state_d = ST_IDLE;
            tgt_d   = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = up_vbus_ok ? ST_HOST : entry_st;
                end
                ST_HOST: begin
                    if (!up_vbus_ok) begin
                        state_d = ST_GAP;
                        tgt_d   = entry_st;
                    end
                end
                ST_DCP_FIX: begin
                    if (up_vbus_ok) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_HOST;
                    end else if (!auto_off) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (up_vbus_ok) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_HOST;
                    end else if (auto_off) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_DCP_FIX;
                    end else if (dp_pullup) begin
                        state_d = ST_GAP;
                        tgt_d   = alt_en ? ST_ALT : ST_DCP_AUTO;
                    end
                end
                ST_ALT: begin
                    if (up_vbus_ok) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_HOST;
                    end else if (auto_off) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_DCP_FIX;
                    end else if (dp_pullup) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_DCP_AUTO;
                    end
                end
                ST_DCP_AUTO: begin
                    if (up_vbus_ok) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_HOST;
                    end else if (auto_off) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_DCP_FIX;
                    end else if (!held_q && !detect && (win_cnt >= WAIT_C)) begin
                        state_d = ST_GAP;
                        tgt_d   = ST_DIV;
                    end
                end
                ST_GAP: begin
                    if (up_vbus_ok && (tgt_q != ST_HOST)) begin
                        tgt_d    = ST_HOST;
                        retarget = 1'b1;
                    end else if (!up_vbus_ok && (tgt_q == ST_HOST)) begin
                        tgt_d    = entry_st;
                        retarget = 1'b1;
                    end else if (!auto_off && (tgt_q == ST_DCP_FIX)) begin
                        tgt_d    = ST_DIV;
                        retarget = 1'b1;
                    end else if (auto_off && tgt_auto) begin
                        tgt_d    = ST_DCP_FIX;
                        retarget = 1'b1;
                    end else if (gap_cnt >= gap_len) begin
                        state_d = tgt_q;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    tgt_d   = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        state    = state_q;
        target   = tgt_q;
        gap_clr  = (state_q != ST_GAP) || retarget;
        win_clr  = (state_q != ST_DCP_AUTO) || held_q;
        power_on = (state_q != ST_IDLE) && (state_q != ST_GAP);
    end
endmodule

// File: rtl/chg_mode_decode.sv
module chg_mode_decode
    import chg_seq_pkg::*;
(
    input  chg_state_e        state,
    input  chg_state_e        target,
    input  logic              hicur_en,
    input  logic              power_on,
    input  logic              pwr_pol,
    output logic [MODE_W-1:0] mode_oh,
    output logic              port_pwr
);
    chg_state_e shown;
    int         idx;

    assign shown = (state == ST_GAP) ? target : state;
    assign idx   = mode_index(shown, hicur_en);

    for (genvar gi = 0; gi < MODE_W; gi++) begin : g_mode_bit
        assign mode_oh[gi] = (idx == gi);
    end

    assign port_pwr = ~(power_on ^ pwr_pol);
endmodule

// File: rtl/chg_port_seq.sv
module chg_port_seq
    import chg_seq_pkg::*;
#(
    parameter int GAP_SEL_W      = 3,
    parameter int GAP_UNIT_TICKS = 200,
    parameter int DCP_WAIT_TICKS = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 chg_en,
    input  logic                 up_vbus_ok,
    input  logic                 auto_off,
    input  logic                 hicur_en,
    input  logic                 alt_en,
    input  logic                 dp_pullup,
    input  logic                 dat_det,
    input  logic [GAP_SEL_W-1:0] gap_sel,
    input  logic                 pwr_pol,
    output logic [5:0]           mode_oh,
    output logic                 port_pwr
);
    localparam int GAP_MAX = ((1 << GAP_SEL_W) - 1) * GAP_UNIT_TICKS;
    localparam int CNT_MAX = (GAP_MAX > DCP_WAIT_TICKS) ? GAP_MAX : DCP_WAIT_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 2);

    chg_state_e       state, target;
    logic             gap_clr, win_clr, power_on;
    logic [CNT_W-1:0] gap_cnt, win_cnt;

    chg_mode_fsm #(
        .CNT_W          (CNT_W),
        .GAP_SEL_W      (GAP_SEL_W),
        .GAP_UNIT_TICKS (GAP_UNIT_TICKS),
        .DCP_WAIT_TICKS (DCP_WAIT_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chg_en     (chg_en),
        .up_vbus_ok (up_vbus_ok),
        .auto_off   (auto_off),
        .alt_en     (alt_en),
        .dp_pullup  (dp_pullup),
        .dat_det    (dat_det),
        .gap_sel    (gap_sel),
        .gap_cnt    (gap_cnt),
        .win_cnt    (win_cnt),
        .state      (state),
        .target     (target),
        .gap_clr    (gap_clr),
        .win_clr    (win_clr),
        .power_on   (power_on)
    );

    chg_tick_timer #(.CNT_W(CNT_W)) u_gap_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gap_clr),
        .tick  (tick),
        .cnt   (gap_cnt)
    );

    chg_tick_timer #(.CNT_W(CNT_W)) u_win_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .tick  (tick),
        .cnt   (win_cnt)
    );

    chg_mode_decode u_dec (
        .state    (state),
        .target   (target),
        .hicur_en (hicur_en),
        .power_on (power_on),
        .pwr_pol  (pwr_pol),
        .mode_oh  (mode_oh),
        .port_pwr (port_pwr)
    );
endmodule

// File: rtl/chg_port_seq_chk.sv
module chg_port_seq_chk #(
    parameter int DCP_WAIT_TICKS = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       chg_en,
    input logic       up_vbus_ok,
    input logic       auto_off,
    input logic       dp_pullup,
    input logic       dat_det,
    input logic       pwr_pol,
    input logic [5:0] mode_oh,
    input logic       port_pwr
);
    logic        act;
    logic        run;
    logic        tainted_q;
    logic [31:0] run_ticks_q;

    assign act = pwr_pol ? port_pwr : !port_pwr;
    assign run = chg_en && !up_vbus_ok && !auto_off && mode_oh[2] && act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_ticks_q <= '0;
            tainted_q   <= 1'b0;
        end else if (run) begin
            run_ticks_q <= run_ticks_q + {31'd0, tick};
            tainted_q   <= tainted_q | dp_pullup | dat_det;
        end else begin
            run_ticks_q <= '0;
            tainted_q   <= 1'b0;
        end
    end

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_oh) == 1);

    p_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en |=> (mode_oh == 6'b000001) && !act);

    p_host_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en && up_vbus_ok && mode_oh[1] && act) |=> (mode_oh[1] && act));

    p_fixed_dcp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en && !up_vbus_ok && auto_off && $past(auto_off) && mode_oh[2] && act)
            |=> (mode_oh[2] && act));

    p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en && !up_vbus_ok && !auto_off && !dp_pullup && (mode_oh[3] || mode_oh[4]) && act)
            |=> ((mode_oh[3] || mode_oh[4]) && act));

    p_dcp_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tainted_q) |-> (run_ticks_q <= 32'(DCP_WAIT_TICKS)));
endmodule

bind chg_port_seq chg_port_seq_chk #(
    .DCP_WAIT_TICKS (DCP_WAIT_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .chg_en     (chg_en),
    .up_vbus_ok (up_vbus_ok),
    .auto_off   (auto_off),
    .dp_pullup  (dp_pullup),
    .dat_det    (dat_det),
    .pwr_pol    (pwr_pol),
    .mode_oh    (mode_oh),
    .port_pwr   (port_pwr)
);

// File: tb/chg_port_seq_tb.sv
`timescale 1ns/1ps
module chg_port_seq_tb;
    localparam int UNIT = 2;
    localparam int WAIT = 10;

    localparam logic [5:0] M_NONE = 6'b000001;
    localparam logic [5:0] M_CDP  = 6'b000010;
    localparam logic [5:0] M_DCP  = 6'b000100;
    localparam logic [5:0] M_ACP1 = 6'b001000;
    localparam logic [5:0] M_ACP2 = 6'b010000;
    localparam logic [5:0] M_ALT  = 6'b100000;

    // {en, vbus, auto_off, hicur, alt, pol, mode[5:0], pin}
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_0_0_0_0_1_000001_0,
        13'b1_1_0_0_0_1_000010_1,
        13'b1_0_1_0_0_1_000100_1,
        13'b1_0_0_0_0_1_001000_1,
        13'b1_0_0_1_0_0_010000_0,
        13'b1_1_1_0_0_0_000010_0,
        13'b0_1_0_0_0_0_000001_1,
        13'b1_0_1_0_0_0_000100_0
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick = 1;
    logic       chg_en = 0, up_vbus_ok = 0, auto_off = 0, hicur_en = 0, alt_en = 0;
    logic       dp_pullup = 0, dat_det = 0, pwr_pol = 1;
    logic [2:0] gap_sel = 3'd1;
    logic [5:0] mode_oh;
    logic       port_pwr;

    int checks = 0;
    int errors = 0;
    int n;

    always #2 clk = ~clk;

    chg_port_seq #(
        .GAP_SEL_W(3), .GAP_UNIT_TICKS(UNIT), .DCP_WAIT_TICKS(WAIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chg_en(chg_en),
        .up_vbus_ok(up_vbus_ok), .auto_off(auto_off), .hicur_en(hicur_en),
        .alt_en(alt_en), .dp_pullup(dp_pullup), .dat_det(dat_det),
        .gap_sel(gap_sel), .pwr_pol(pwr_pol), .mode_oh(mode_oh), .port_pwr(port_pwr)
    );

    function automatic logic active();
        return pwr_pol ? port_pwr : !port_pwr;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic count_run(input logic want, output int cnt);
        cnt = 0;
        while ((active() == want) && (cnt < 1000)) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_pullup();
        dp_pullup = 1;
        @(negedge clk);
        dp_pullup = 0;
    endtask

    initial begin
        for (int w = 0; w < 100000; w++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset state with charging requested: R1, R9
        chg_en = 1;
        cyc(3);
        chk("R1 reset mode", mode_oh, M_NONE);
        chk("R9 reset pin active-high idle", port_pwr, 0);
        chg_en = 0;
        rst_n = 1;
        cyc(2);

        // table walk: R1 R2 R3 R4 R9 R10
        for (int v = 0; v < NV; v++) begin
            chg_en     = VEC[v][12];
            up_vbus_ok = VEC[v][11];
            auto_off   = VEC[v][10];
            hicur_en   = VEC[v][9];
            alt_en     = VEC[v][8];
            pwr_pol    = VEC[v][7];
            cyc(20);
            chk($sformatf("R2/R3/R4 vec%0d mode", v), mode_oh, VEC[v][6:1]);
            chk($sformatf("R9 vec%0d pin", v), port_pwr, VEC[v][0]);
        end

        // automatic cycle with alternate step: R4 R5 R6 R7 R8
        chg_en = 1; up_vbus_ok = 0; auto_off = 0; hicur_en = 0; alt_en = 1;
        pwr_pol = 1; gap_sel = 3'd1;
        cyc(10);
        chk("R4 entry ACP1", mode_oh, M_ACP1);
        pulse_pullup();
        chk("R8 gap shows target", mode_oh, M_ALT);
        chk("R8 gap power off", port_pwr, 0);
        count_run(1'b0, n);
        chk("R8 gap length sel1", n, 1 * UNIT + 1);
        chk("R5 divider to alt", mode_oh, M_ALT);
        cyc(5);
        chk("R5 alt holds", mode_oh, M_ALT);
        gap_sel = 3'd3;
        pulse_pullup();
        count_run(1'b0, n);
        chk("R8 gap length sel3", n, 3 * UNIT + 1);
        chk("R6 alt to dcp", mode_oh, M_DCP);
        count_run(1'b1, n);
        chk("R7 dcp window cycles", n, WAIT + 1);
        chk("R7 window expiry target", mode_oh, M_ACP1);
        count_run(1'b0, n);
        chk("R7 back to divider", mode_oh, M_ACP1);

        // alternate disabled, high current: R4 R5
        alt_en = 0; hicur_en = 1; gap_sel = 3'd1;
        cyc(2);
        chk("R4 entry ACP2", mode_oh, M_ACP2);
        pulse_pullup();
        count_run(1'b0, n);
        chk("R5 divider to dcp without alt", mode_oh, M_DCP);

        // data-voltage detect holds DCP: R7
        dat_det = 1;
        @(negedge clk);
        dat_det = 0;
        cyc(40);
        chk("R7 detect holds dcp", mode_oh, M_DCP);
        chk("R7 detect holds power", active(), 1);

        // host arrival from DCP_AUTO and loss: R10
        up_vbus_ok = 1;
        @(negedge clk);
        chk("R10 host gap target", mode_oh, M_CDP);
        count_run(1'b0, n);
        chk("R10 host gap length", n, 1 * UNIT + 1);
        chk("R10 host reached", mode_oh, M_CDP);
        up_vbus_ok = 0;
        @(negedge clk);
        count_run(1'b0, n);
        chk("R10 host loss to divider", mode_oh, M_ACP2);

        // zero gap: R8
        alt_en = 1; gap_sel = 3'd0;
        pulse_pullup();
        count_run(1'b0, n);
        chk("R8 zero gap single cycle", n, 1);
        chk("R8 zero gap target", mode_oh, M_ALT);

        // no tick freezes DCP window: R7
        pulse_pullup();
        count_run(1'b0, n);
        tick = 0;
        cyc(50);
        chk("R7 no tick no expiry", mode_oh, M_DCP);
        tick = 1;
        count_run(1'b1, n);
        chk("R7 resumes then expires", mode_oh, M_ACP2);
        count_run(1'b0, n);

        // disable mid-gap: R1
        gap_sel = 3'd3;
        pulse_pullup();
        @(negedge clk);
        chg_en = 0;
        @(negedge clk);
        chk("R1 disable mid gap mode", mode_oh, M_NONE);
        chk("R1 disable mid gap power", active(), 0);
        chk("R11 onehot at end", $countones(mode_oh), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule